// File: doc/BRIEF.md
# Base Address Region Decoder

This block turns the contents of a function's base-address registers into a live address map. Up to six address registers and one expansion-ROM register describe regions whose type (I/O, 32-bit memory, 64-bit memory or unused) and power-of-two size are fixed by parameters. When the configuration side signals that the registers or the command enables may have changed, the block re-evaluates every region. For each region it decides whether the placement is valid and enabled, and it records the aligned base.

Placements that are zero, that wrap, or that run past the limit of their address space are treated as not mapped. They are never decoded. I/O and memory regions follow different validity rules. A lookup port takes an access type (I/O or memory) and an address. In the same cycle it reports whether any mapped region claims the address, the index of that region, and the offset into it. Several regions may claim the same address. In that case the lowest index is reported and an overlap flag is raised.

Top module: `bar_region_decoder`

## Requirements
- R1: While reset is asserted, and after it until the first remap pulse, every region is unmapped, so every lookup reports no hit and no overlap.
- R2: A remap pulse marks an I/O region as mapped only if the I/O enable input is 1 in that cycle. It marks a memory region, the ROM included, as mapped only if the memory enable input is 1 in that cycle.
- R3: The base of a region of size S is the register value with its low log2(S) bits cleared. A hit reports offset = address − base, which is always below S.
- R4: An I/O region is unmapped if its base is zero, if base + S − 1 wraps, or if base + S − 1 is 0x10000 or more.
- R5: A 32-bit memory region, the ROM included, is unmapped if its base is zero or if base + S − 1 is 0xFFFFFFFF or more. A 64-bit memory region is unmapped if its base is zero or if base + S − 1 wraps past 2^64 − 1.
- R6: The ROM region (index 6 by default) is unmapped whenever bit 0 of the ROM register is 0.
- R7: A 64-bit region at register slot k takes the low half of its base from slot k and the high half from slot k+1. Slot k+1 is not a region of its own.
- R8: A region whose kind is unused never hits, whatever its register holds.
- R9: An I/O lookup (access type input 1) can hit only I/O regions. A memory lookup (access type input 0) can hit only memory regions.
- R10: Mapped flags and bases change only on the clock edge that samples the remap pulse. Register or enable changes without a remap pulse do not alter lookup results.
- R11: When several mapped regions claim the address, the lowest index is reported and the overlap output is 1. With one claimant the overlap output is 0.
- R12: Region kinds are encoded as 0 unused, 1 I/O, 2 32-bit memory, 3 64-bit memory. With default parameters the regions are: index 0 I/O of 16 bytes; index 1 32-bit memory of 4 KiB; index 2 64-bit memory of 64 KiB using slots 2 and 3; indices 3 and 5 unused; index 4 32-bit memory of 256 bytes; index 6 the ROM of 2 KiB. The hit index is 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_io_en | input | 1 | Command-register I/O space enable |
| cmd_mem_en | input | 1 | Command-register memory space enable |
| remap | input | 1 | One-cycle pulse: re-evaluate all regions |
| bar_words | input | NUM_BARS*32 | Address register contents, slot k at bits 32k+31:32k |
| rom_word | input | 32 | Expansion-ROM register contents, bit 0 is the ROM enable |
| acc_io | input | 1 | Lookup access type: 1 I/O, 0 memory |
| acc_addr | input | 64 | Lookup address |
| hit | output | 1 | A mapped region claims the address |
| hit_rgn | output | IDX_W | Index of the claiming region (lowest if several) |
| hit_off | output | 64 | Offset of the address within that region |
| hit_multi | output | 1 | More than one region claims the address |

## Verification
A wrong mapped flag or base inside the block shows up at the lookup port on the first probe near that region's edges after the remap edge. The result is a missing hit, a stray hit, a wrong index, or an offset that does not add back to the address. The bench probes the first and last byte of each region and the bytes just outside it, with both access types, after every configuration. A stale or early register update therefore shows up within one cycle of the remap pulse. A wrong validity limit shows up at the boundary placements chosen just inside and just outside each rule.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
   localparam int ADDR_W = 64;
   localparam int DW_W   = 32;

   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_IO    = 2'd1,
      RK_MEM32 = 2'd2,
      RK_MEM64 = 2'd3
   } rgn_kind_e;

   typedef logic [ADDR_W-1:0] addr_t;

   function automatic addr_t size_of(input int szlog);
      return addr_t'(1) << szlog;
   endfunction

   function automatic addr_t low_mask(input int szlog);
      return size_of(szlog) - addr_t'(1);
   endfunction
endpackage

// File: rtl/bar_region_eval.sv
module bar_region_eval
   import bar_dec_pkg::*;
#(
   parameter logic [1:0]        KIND      = RK_NONE,
   parameter int                SZLOG     = 4,
   parameter bit                IS_ROM    = 1'b0,
   parameter logic [ADDR_W-1:0] IO_TOP    = 64'h0000_0000_0001_0000,
   parameter logic [ADDR_W-1:0] MEM32_TOP = 64'h0000_0000_FFFF_FFFF
) (
   input  logic [DW_W-1:0] lo_dw,
   input  logic [DW_W-1:0] hi_dw,
   input  logic            io_en,
   input  logic            mem_en,
   output logic            map_ok,
   output addr_t           base
);
   localparam addr_t LMASK = low_mask(SZLOG);

   if (SZLOG > 63) begin : g_bad_size
      $error("region size exponent out of range");
   end
   if (KIND == RK_IO && SZLOG < 2) begin : g_bad_io
      $error("I/O region must span at least 4 bytes");
   end
   if ((KIND == RK_MEM32 || KIND == RK_MEM64) && SZLOG < 4) begin : g_bad_mem
      $error("memory region must span at least 16 bytes");
   end
   if (IS_ROM && KIND != RK_MEM32) begin : g_bad_rom
      $error("ROM region must be a 32-bit memory region");
   end

   addr_t raw;
   addr_t last;
   logic  space_en;
   logic  rom_gate;
   logic  bad_common;
   logic  bad_limit;

   if (KIND == RK_MEM64) begin : g_wide
      assign raw = {hi_dw, lo_dw};
   end else begin : g_narrow
      logic unused_hi;
      assign raw       = {{(ADDR_W-DW_W){1'b0}}, lo_dw};
      assign unused_hi = ^hi_dw;
   end

   if (IS_ROM) begin : g_rom
      assign rom_gate = lo_dw[0];
   end else begin : g_plain
      assign rom_gate = 1'b1;
   end

   if (KIND == RK_IO) begin : g_lim_io
      assign bad_limit = (last >= IO_TOP);
   end else if (KIND == RK_MEM32) begin : g_lim_m32
      assign bad_limit = (last >= MEM32_TOP);
   end else begin : g_lim_none
      assign bad_limit = 1'b0;
   end

   assign space_en   = (KIND == RK_IO) ? io_en : mem_en;
   assign base       = raw & ~LMASK;
   assign last       = base + LMASK;
   assign bad_common = (base == '0) || (last <= base);
   assign map_ok     = (KIND != RK_NONE) && space_en && rom_gate &&
                       !bad_common && !bad_limit;
endmodule

// File: rtl/bar_hit_select.sv
module bar_hit_select
   import bar_dec_pkg::*;
#(
   parameter int NUM   = 7,
   parameter int IDX_W = 3
) (
   input  logic [NUM-1:0]         match,
   input  logic [NUM-1:0][ADDR_W-1:0] offs,
   output logic                   hit,
   output logic [IDX_W-1:0]       idx,
   output addr_t                  off,
   output logic                   multi
);
   if ((1 << IDX_W) < NUM) begin : g_bad_idx
      $error("index width too small for region count");
   end

   always_comb begin
      idx = '0;
      off = '0;
      for (int r = NUM - 1; r >= 0; r--) begin
         if (match[r]) begin
            idx = IDX_W'(r);
            off = offs[r];
         end
      end
   end

   assign hit   = |match;
   assign multi = ($countones(match) > 1);
endmodule

// File: rtl/bar_region_decoder.sv
module bar_region_decoder
   import bar_dec_pkg::*;
#(
   parameter int                   NUM_BARS  = 6,
   parameter logic [2*NUM_BARS-1:0] BAR_KIND = {2'd0, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1},
   parameter logic [6*NUM_BARS-1:0] BAR_SZLOG = {6'd0, 6'd8, 6'd0, 6'd16, 6'd12, 6'd4},
   parameter int                   ROM_SZLOG = 11,
   parameter logic [63:0]          IO_TOP    = 64'h0000_0000_0001_0000,
   parameter int                   NUM_RGN   = NUM_BARS + 1,
   parameter int                   IDX_W     = $clog2(NUM_RGN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_io_en,
   input  logic                     cmd_mem_en,
   input  logic                     remap,
   input  logic [NUM_BARS*32-1:0]   bar_words,
   input  logic [31:0]              rom_word,
   input  logic                     acc_io,
   input  logic [63:0]              acc_addr,
   output logic                     hit,
   output logic [IDX_W-1:0]         hit_rgn,
   output logic [63:0]              hit_off,
   output logic                     hit_multi
);
   localparam int ROM_IDX = NUM_BARS;

   if (NUM_BARS < 1 || NUM_BARS > 6) begin : g_bad_nbars
      $error("register slot count must be 1 to 6");
   end
   if (NUM_RGN != NUM_BARS + 1) begin : g_bad_nrgn
      $error("region count must be slot count plus one");
   end

   logic [NUM_RGN-1:0]             nx_map;
   logic [NUM_RGN-1:0][ADDR_W-1:0] nx_base;
   logic [NUM_RGN-1:0]             map_q;
   logic [NUM_RGN-1:0][ADDR_W-1:0] base_q;
   logic [NUM_RGN-1:0]             match;
   logic [NUM_RGN-1:0][ADDR_W-1:0] offs;

   // ---------------- per-slot evaluation ----------------
   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam logic [1:0] KND = BAR_KIND[2*i +: 2];
      localparam int         SZL = int'(BAR_SZLOG[6*i +: 6]);
      logic [DW_W-1:0] hi_w;

      if (KND == RK_MEM64) begin : g_hi
         if (i + 1 >= NUM_BARS) begin : g_bad_last
            $error("64-bit region cannot use the last slot");
         end else begin : g_take
            assign hi_w = bar_words[32*(i+1) +: 32];
            if (BAR_KIND[2*(i+1) +: 2] != RK_NONE) begin : g_bad_pair
               $error("slot after a 64-bit region must be unused");
            end
         end
      end else begin : g_nohi
         assign hi_w = '0;
      end

      bar_region_eval #(
         .KIND   (KND),
         .SZLOG  (SZL),
         .IS_ROM (1'b0),
         .IO_TOP (IO_TOP)
      ) u_eval (
         .lo_dw  (bar_words[32*i +: 32]),
         .hi_dw  (hi_w),
         .io_en  (cmd_io_en),
         .mem_en (cmd_mem_en),
         .map_ok (nx_map[i]),
         .base   (nx_base[i])
      );
   end

   // ---------------- expansion ROM ----------------
   if (ROM_SZLOG > 0) begin : g_rom
      bar_region_eval #(
         .KIND   (RK_MEM32),
         .SZLOG  (ROM_SZLOG),
         .IS_ROM (1'b1),
         .IO_TOP (IO_TOP)
      ) u_eval (
         .lo_dw  (rom_word),
         .hi_dw  ('0),
         .io_en  (cmd_io_en),
         .mem_en (cmd_mem_en),
         .map_ok (nx_map[ROM_IDX]),
         .base   (nx_base[ROM_IDX])
      );

      // ROM enable bit clear forbids mapping
      p_rom_gate_r6 : assert property (@(posedge clk) disable iff (!rst_n)
         (remap && !rom_word[0]) |=> !map_q[ROM_IDX]);
   end else begin : g_norom
      logic unused_rom;
      assign unused_rom       = ^rom_word;
      assign nx_map[ROM_IDX]  = 1'b0;
      assign nx_base[ROM_IDX] = '0;
   end

   // ---------------- decoded state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q  <= '0;
         base_q <= '0;
      end else if (remap) begin
         map_q  <= nx_map;
         base_q <= nx_base;
      end
   end

   // ---------------- lookup ----------------
   for (genvar r = 0; r < NUM_RGN; r++) begin : g_look
      localparam logic [1:0] KND = (r == ROM_IDX) ?
         ((ROM_SZLOG > 0) ? 2'(RK_MEM32) : 2'(RK_NONE)) : BAR_KIND[2*r +: 2];
      localparam int SZL = (r == ROM_IDX) ? ROM_SZLOG : int'(BAR_SZLOG[6*r +: 6]);
      localparam addr_t LM = low_mask(SZL);
      localparam bit IS_IO = (KND == RK_IO);

      assign match[r] = map_q[r] && (acc_io == IS_IO) &&
                        ((acc_addr & ~LM) == base_q[r]);
      assign offs[r]  = acc_addr & LM;

      if (r < NUM_BARS) begin : g_gate_chk
         if (KND == RK_IO) begin : g_io
            p_io_gate_r2 : assert property (@(posedge clk) disable iff (!rst_n)
               (remap && !cmd_io_en) |=> !map_q[r]);
         end else if (KND == RK_NONE) begin : g_none
            p_unused_r8 : assert property (@(posedge clk) disable iff (!rst_n)
               remap |=> !map_q[r]);
         end else begin : g_mem
            p_mem_gate_r2 : assert property (@(posedge clk) disable iff (!rst_n)
               (remap && !cmd_mem_en) |=> !map_q[r]);
         end
      end
   end

   bar_hit_select #(
      .NUM   (NUM_RGN),
      .IDX_W (IDX_W)
   ) u_sel (
      .match (match),
      .offs  (offs),
      .hit   (hit),
      .idx   (hit_rgn),
      .off   (hit_off),
      .multi (hit_multi)
   );

   // ---------------- assertions ----------------
   p_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !remap |=> ($stable(map_q) && $stable(base_q)));

   p_hit_mapped_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> map_q[hit_rgn]);

   p_offset_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((base_q[hit_rgn] + hit_off) == acc_addr));

   p_multi_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_multi |-> hit);
endmodule

// File: tb/bar_region_decoder_tb.sv
module bar_region_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_io_en, cmd_mem_en, remap;
   logic [191:0] bar_words;
   logic [31:0] rom_word;
   logic        acc_io;
   logic [63:0] acc_addr;
   logic        hit;
   logic [2:0]  hit_rgn;
   logic [63:0] hit_off;
   logic        hit_multi;

   always #2 clk = ~clk;

   bar_region_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
      .remap(remap), .bar_words(bar_words), .rom_word(rom_word),
      .acc_io(acc_io), .acc_addr(acc_addr), .hit(hit), .hit_rgn(hit_rgn),
      .hit_off(hit_off), .hit_multi(hit_multi));

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // R12 default layout: kind 0 none, 1 io, 2 mem32, 3 mem64
   int          m_kind [7] = '{1, 2, 3, 0, 2, 0, 2};
   int          m_szl  [7] = '{4, 12, 16, 0, 8, 0, 11};
   logic        m_map  [7];
   logic [63:0] m_base [7];
   logic [31:0] bw [6];
   logic [31:0] romw;
   logic        io_e, mem_e;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected completion earlier", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   function automatic void model_eval();
      for (int r = 0; r < 7; r++) begin
         logic [63:0] raw, sz, bs, lst;
         logic ok;
         sz = 64'd1 << m_szl[r];
         if (r == 6) raw = {32'd0, romw};
         else if (m_kind[r] == 3) raw = {bw[r+1], bw[r]};
         else raw = {32'd0, bw[r]};
         bs  = raw - (raw % sz);
         lst = bs + sz - 64'd1;
         ok = (m_kind[r] != 0) && (bs != 0) && (lst > bs);
         if (m_kind[r] == 1) ok = ok && io_e && (lst < 64'h10000);
         else ok = ok && mem_e;
         if (m_kind[r] == 2) ok = ok && (lst < 64'hFFFF_FFFF);
         if (r == 6) ok = ok && romw[0];
         m_map[r]  = ok;
         m_base[r] = bs;
      end
   endfunction

   task automatic drive_ports();
      for (int k = 0; k < 6; k++) bar_words[32*k +: 32] = bw[k];
      rom_word   = romw;
      cmd_io_en  = io_e;
      cmd_mem_en = mem_e;
   endtask

   task automatic apply_cfg();
      @(negedge clk);
      drive_ports();
      remap = 1'b1;
      @(negedge clk);
      remap = 1'b0;
      model_eval();
   endtask

   task automatic probe(input logic io, input logic [63:0] a, input string tag);
      logic        e_hit, e_multi;
      logic [2:0]  e_rgn;
      logic [63:0] e_off;
      int          cnt;
      @(negedge clk);
      acc_io = io;
      acc_addr = a;
      #1;
      e_hit = 0; e_multi = 0; e_rgn = 0; e_off = 0; cnt = 0;
      for (int r = 0; r < 7; r++) begin
         logic [63:0] sz;
         sz = 64'd1 << m_szl[r];
         if (m_map[r] && ((m_kind[r] == 1) == io) && a >= m_base[r] &&
             a <= m_base[r] + sz - 64'd1) begin
            if (cnt == 0) begin
               e_rgn = 3'(r);
               e_off = a - m_base[r];
            end
            cnt++;
         end
      end
      e_hit = (cnt > 0);
      e_multi = (cnt > 1);
      n_chk++;
      if (hit !== e_hit || hit_multi !== e_multi ||
          (e_hit && (hit_rgn !== e_rgn || hit_off !== e_off))) begin
         n_fail++;
         $display("FAIL %s: io=%0b addr=%h hit=%0b exp %0b rgn=%0d exp %0d off=%h exp %h multi=%0b exp %0b",
                  tag, io, a, hit, e_hit, hit_rgn, e_rgn, hit_off, e_off, hit_multi, e_multi);
      end
   endtask

   task automatic sweep(input string tag);
      for (int r = 0; r < 7; r++) begin
         logic [63:0] sz;
         logic [63:0] pts [4];
         if (m_kind[r] == 0) continue;
         sz = 64'd1 << m_szl[r];
         pts[0] = m_base[r];
         pts[1] = m_base[r] + sz - 64'd1;
         pts[2] = m_base[r] - 64'd1;
         pts[3] = m_base[r] + sz;
         for (int p = 0; p < 4; p++) begin
            probe(m_kind[r] == 1, pts[p], tag);
            probe(m_kind[r] != 1, pts[p], {tag, " R9"});
         end
         probe(m_kind[r] == 1, m_base[r] + (sz >> 1) + 64'd3, {tag, " R3"});
      end
   endtask

   task automatic base_cfg();
      io_e = 1; mem_e = 1;
      bw[0] = 32'h0000_C001;
      bw[1] = 32'hF000_0000;
      bw[2] = 32'h8000_000C;
      bw[3] = 32'h0000_0001;
      bw[4] = 32'hE000_0100;
      bw[5] = 32'hD000_0000;
      romw  = 32'hF100_0001;
   endtask

   initial begin
      rst_n = 0; remap = 0; acc_io = 0; acc_addr = '0;
      io_e = 0; mem_e = 0; romw = '0;
      for (int k = 0; k < 6; k++) bw[k] = '0;
      drive_ports();
      for (int r = 0; r < 7; r++) begin m_map[r] = 0; m_base[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: nothing mapped after reset
      probe(1, 64'h0000_C000, "R1");
      probe(0, 64'hF000_0000, "R1");
      probe(0, 64'h0, "R1");

      // R3 / R12: full configuration
      base_cfg(); apply_cfg();
      sweep("R3");
      probe(0, 64'hF100_0004, "R12 rom index 6");
      probe(0, 64'h1_8000_1234, "R7 wide index 2");
      probe(0, 64'h0_8000_1234, "R7 high half matters");
      // R8: unused slots hold a plausible address
      probe(0, 64'hD000_0000, "R8");
      probe(0, 64'h0000_0001_0000_0000, "R8");

      // R2: enables
      io_e = 0; apply_cfg(); sweep("R2 io off");
      io_e = 1; mem_e = 0; apply_cfg(); sweep("R2 mem off");

      // R4: I/O limits
      base_cfg();
      bw[0] = 32'h0000_FFF1; apply_cfg(); sweep("R4 top fits");
      bw[0] = 32'h0001_0001; apply_cfg(); sweep("R4 past 64K");
      probe(1, 64'h0001_0000, "R4 past 64K");
      bw[0] = 32'h0000_0005; apply_cfg(); sweep("R4 zero base");
      probe(1, 64'h0, "R4 zero base");

      // R5: memory limits
      base_cfg();
      bw[1] = 32'hFFFF_F000; apply_cfg(); sweep("R5 hits ceiling");
      probe(0, 64'hFFFF_F800, "R5 hits ceiling");
      bw[1] = 32'hFFFF_E000; apply_cfg(); sweep("R5 below ceiling");
      bw[1] = 32'h0000_0008; apply_cfg(); sweep("R5 zero base");
      bw[2] = 32'hFFFE_000C; bw[3] = 32'hFFFF_FFFF; apply_cfg(); sweep("R5 wide near top");
      probe(0, 64'hFFFF_FFFF_FFFE_8000, "R5 wide near top");
      bw[2] = 32'h0000_000C; bw[3] = 32'h0000_0000; apply_cfg(); sweep("R7 wide zero");

      // R6: ROM enable bit
      base_cfg(); romw = 32'hF100_0000; apply_cfg(); sweep("R6");
      probe(0, 64'hF100_0000, "R6");

      // R11: overlap of regions 1 and 4
      base_cfg(); bw[1] = 32'hE000_0000; apply_cfg(); sweep("R11");
      probe(0, 64'hE000_0180, "R11 overlap");
      probe(0, 64'hE000_0080, "R11 single");

      // R10: changes without remap are ignored
      base_cfg(); apply_cfg();
      @(negedge clk);
      bw[0] = 32'h0000_A001; bw[1] = 32'hC000_0000; romw = 32'h0;
      io_e = 0; mem_e = 0;
      drive_ports();
      sweep("R10");
      probe(0, 64'hC000_0010, "R10");
      model_eval();
      remap = 1'b1; @(negedge clk); remap = 1'b0;
      sweep("R10 after pulse");

      // R1: reset clears a live map
      io_e = 1; mem_e = 1; base_cfg(); apply_cfg();
      @(negedge clk); rst_n = 0;
      for (int r = 0; r < 7; r++) m_map[r] = 0;
      sweep("R1 reset again");
      @(negedge clk); rst_n = 1;
      sweep("R1 after release");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule